// File: doc/BRIEF.md
# Fractional PLL Coefficient Calculator

This block turns a reference clock frequency and a wanted output frequency into the settings for a fractional-N synthesizer. It returns an integer feedback multiplier, an 18-bit fractional multiplier, the fixed pre-divider and post-divider, a high-band flag with its matching band code, and a rounded sigma-delta divider value. A one-cycle `start` pulse captures both operands. When `busy` falls, `done` pulses for one cycle and every result is valid. The results then hold until the next calculation completes.

All arithmetic runs through one shared restoring divider. The divider returns one quotient bit per clock. A calculation is a fixed chain of seven divisions, so every calculation that completes without error takes the same number of cycles. The reference input `clkin_hz` is in Hz. The target `target` is in units of 10 kHz. Before any other step, the reference is converted to 10 kHz units by truncating division by 10000. If an operand pair would overflow a result field, or would give a zero comparison frequency, the block raises `err` instead of returning wrong numbers.

Top module: `pllc_top`

## Requirements
- R1: While reset is held, and after reset until the first completed calculation, `busy`, `done`, `err`, `mult`, `frac`, `sd_val` and `hi_range` are 0.
- R2: The scaled reference is c = floor(clkin_hz / 10000). The comparison frequency is r = floor(c / 16). `pre_div` always reads 16 and `post_div` always reads 1.
- R3: `mult` = floor(target / r), reported as a 12-bit field.
- R4: `frac` = floor(((target mod r) * 262144) / r). This value is always below 2^18.
- R5: `hi_range` is 1 only when target is strictly greater than 100000. `range_sel` is 3'b100 when `hi_range` is 1 and 3'b010 otherwise.
- R6: `sd_val` = floor((floor(floor(mult * c / 10) / 4000) + 5) / 10), where each division truncates.
- R7: `err` is 1 in any of these cases: r is 0, the full quotient for `mult` is 4096 or more, or the `sd_val` result does not fit in 8 bits. When `err` is 1, `mult`, `frac` and `sd_val` read 0, while `hi_range` and `range_sel` still follow R5.
- R8: `done` is high for exactly one cycle per calculation and is never high together with `busy`. `busy` rises the cycle after a start is accepted and falls in the cycle in which `done` rises.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running calculation finishes with its own operands and its usual latency.
- R10: Every calculation that completes without error takes the same number of cycles from start to `done`, whatever the operand values.
- R11: All result outputs hold their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; captures the operands when idle |
| clkin_hz | input | 32 | Reference clock frequency in Hz |
| target | input | 32 | Wanted output frequency in 10 kHz units |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse; results are valid |
| err | output | 1 | Operands overflow a field, or the comparison frequency is zero |
| mult | output | 12 | Integer feedback multiplier |
| frac | output | 18 | Fractional multiplier, scaled by 2^18 |
| pre_div | output | 8 | Pre-divider value (fixed at 16) |
| post_div | output | 7 | Post-divider value (fixed at 1) |
| hi_range | output | 1 | Target above 1000 MHz |
| sd_val | output | 8 | Rounded sigma-delta divider |
| range_sel | output | 3 | Oscillator band code |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of the division chain. The block must discard it without disturbing the captured operands or the latency. The bench first measures the latency of a clean calculation. It then starts a second calculation and, partway through, pulses `start` with a different operand pair. It checks that the results and the cycle count match the first pair. The three error exits are each driven by a crafted operand pair that trips exactly one of them: a reference below 160000 Hz, a target just past the 12-bit multiplier limit, and a high reference with a large target that makes the sigma-delta value overflow.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLK,
    ST_REF,
    ST_MUL,
    ST_FRAC,
    ST_SD1,
    ST_SD2,
    ST_SD3,
    ST_DONE
  } pllc_state_e;

  localparam logic [2:0] BAND_LOW  = 3'b010;
  localparam logic [2:0] BAND_HIGH = 3'b100;

  localparam int UNIT_SCALE = 10000;
  localparam int SD_STEP    = 250;
  localparam int SD_ROUND   = 5;
  localparam int SD_TEN     = 10;

endpackage

// File: rtl/pllc_divider.sv
module pllc_divider #(
  parameter int W = 50
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         busy,
  output logic         done
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       trial;
  logic [W:0]       diff;
  logic             fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CNT_W'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;

  // R10
  go_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !go);

  // R10
  div_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: rtl/pllc_range.sv
module pllc_range #(
  parameter int FREQ_W   = 32,
  parameter int HI_LIMIT = 100000
) (
  input  logic [FREQ_W-1:0] target,
  output logic              hi,
  output logic [2:0]        code
);
  import pllc_pkg::*;

  always_comb begin
    hi   = (target > FREQ_W'(HI_LIMIT));
    code = hi ? BAND_HIGH : BAND_LOW;
  end

endmodule

// File: rtl/pllc_seq.sv
module pllc_seq
  import pllc_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int M_W     = 12,
  parameter int FRAC_W  = 18,
  parameter int SD_W    = 8,
  parameter int PRE_DIV = 16,
  parameter int DIV_W   = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] clkin_hz,
  input  logic [FREQ_W-1:0] target,
  input  logic              div_busy,
  input  logic              div_done,
  input  logic [DIV_W-1:0]  div_quo,
  input  logic [DIV_W-1:0]  div_rem,
  output logic              div_go,
  output logic [DIV_W-1:0]  div_dvd,
  output logic [DIV_W-1:0]  div_dvs,
  output logic [FREQ_W-1:0] tgt_q,
  input  logic              hi_flag,
  input  logic [2:0]        hi_code,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [M_W-1:0]    mult_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [SD_W-1:0]   sd_o,
  output logic              hi_o,
  output logic [2:0]        rsel_o
);

  localparam int SD_DIV = PRE_DIV * SD_STEP;

  pllc_state_e        state;
  logic               issued;
  logic               fail_r;
  logic [FREQ_W-1:0]  clkin_r;
  logic [DIV_W-1:0]   clk10_r;
  logic [DIV_W-1:0]   ref_r;
  logic [DIV_W-1:0]   rem_r;
  logic [DIV_W-1:0]   tmp_r;
  logic [M_W-1:0]     mul_r;
  logic [FRAC_W-1:0]  frac_r;
  logic [SD_W-1:0]    sd_r;
  logic               in_div;

  assign in_div = (state != ST_IDLE) && (state != ST_DONE);
  assign div_go = in_div && !issued && !div_busy;

  always_comb begin
    div_dvd = '0;
    div_dvs = '0;
    case (state)
      ST_CLK: begin
        div_dvd = DIV_W'(clkin_r);
        div_dvs = DIV_W'(UNIT_SCALE);
      end
      ST_REF: begin
        div_dvd = clk10_r;
        div_dvs = DIV_W'(PRE_DIV);
      end
      ST_MUL: begin
        div_dvd = DIV_W'(tgt_q);
        div_dvs = ref_r;
      end
      ST_FRAC: begin
        div_dvd = rem_r << FRAC_W;
        div_dvs = ref_r;
      end
      ST_SD1: begin
        div_dvd = DIV_W'(mul_r) * clk10_r;
        div_dvs = DIV_W'(SD_TEN);
      end
      ST_SD2: begin
        div_dvd = tmp_r;
        div_dvs = DIV_W'(SD_DIV);
      end
      ST_SD3: begin
        div_dvd = tmp_r + DIV_W'(SD_ROUND);
        div_dvs = DIV_W'(SD_TEN);
      end
      default: begin
        div_dvd = '0;
        div_dvs = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      issued  <= 1'b0;
      fail_r  <= 1'b0;
      clkin_r <= '0;
      tgt_q   <= '0;
      clk10_r <= '0;
      ref_r   <= '0;
      rem_r   <= '0;
      tmp_r   <= '0;
      mul_r   <= '0;
      frac_r  <= '0;
      sd_r    <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      mult_o  <= '0;
      frac_o  <= '0;
      sd_o    <= '0;
      hi_o    <= 1'b0;
      rsel_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            clkin_r <= clkin_hz;
            tgt_q   <= target;
            fail_r  <= 1'b0;
            busy_o  <= 1'b1;
            state   <= ST_CLK;
          end
        end
        ST_DONE: begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          err_o  <= fail_r;
          mult_o <= fail_r ? '0 : mul_r;
          frac_o <= fail_r ? '0 : frac_r;
          sd_o   <= fail_r ? '0 : sd_r;
          hi_o   <= hi_flag;
          rsel_o <= hi_code;
          state  <= ST_IDLE;
        end
        default: begin
          if (!issued) begin
            if (!div_busy) issued <= 1'b1;
          end else if (div_done) begin
            issued <= 1'b0;
            case (state)
              ST_CLK: begin
                clk10_r <= div_quo;
                state   <= ST_REF;
              end
              ST_REF: begin
                ref_r <= div_quo;
                if (div_quo == '0) begin
                  fail_r <= 1'b1;
                  state  <= ST_DONE;
                end else begin
                  state <= ST_MUL;
                end
              end
              ST_MUL: begin
                if (|div_quo[DIV_W-1:M_W]) begin
                  fail_r <= 1'b1;
                  state  <= ST_DONE;
                end else begin
                  mul_r <= div_quo[M_W-1:0];
                  rem_r <= div_rem;
                  state <= ST_FRAC;
                end
              end
              ST_FRAC: begin
                frac_r <= div_quo[FRAC_W-1:0];
                state  <= ST_SD1;
              end
              ST_SD1: begin
                tmp_r <= div_quo;
                state <= ST_SD2;
              end
              ST_SD2: begin
                tmp_r <= div_quo;
                state <= ST_SD3;
              end
              ST_SD3: begin
                if (|div_quo[DIV_W-1:SD_W]) begin
                  fail_r <= 1'b1;
                end else begin
                  sd_r <= div_quo[SD_W-1:0];
                end
                state <= ST_DONE;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R4
  frac_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRAC && issued && div_done) |-> ((div_quo >> FRAC_W) == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && state != ST_DONE) |=> busy_o);

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (mult_o == '0 && frac_o == '0 && sd_o == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(mult_o) && $stable(frac_o) && $stable(sd_o) &&
                 $stable(err_o) && $stable(hi_o)));

endmodule

// File: rtl/pllc_top.sv
module pllc_top #(
  parameter int FREQ_W   = 32,
  parameter int M_W      = 12,
  parameter int FRAC_W   = 18,
  parameter int SD_W     = 8,
  parameter int PRE_DIV  = 16,
  parameter int PDIV_W   = 8,
  parameter int POST_W   = 7,
  parameter int HI_LIMIT = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] clkin_hz,
  input  logic [FREQ_W-1:0] target,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [M_W-1:0]    mult,
  output logic [FRAC_W-1:0] frac,
  output logic [PDIV_W-1:0] pre_div,
  output logic [POST_W-1:0] post_div,
  output logic              hi_range,
  output logic [SD_W-1:0]   sd_val,
  output logic [2:0]        range_sel
);

  localparam int EXT_W = (FRAC_W > M_W) ? FRAC_W : M_W;
  localparam int DIV_W = FREQ_W + EXT_W;

  logic              div_go;
  logic              div_busy;
  logic              div_done;
  logic [DIV_W-1:0]  div_dvd;
  logic [DIV_W-1:0]  div_dvs;
  logic [DIV_W-1:0]  div_quo;
  logic [DIV_W-1:0]  div_rem;
  logic [FREQ_W-1:0] tgt_q;
  logic              hi_flag;
  logic [2:0]        hi_code;

  pllc_divider #(.W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .go        (div_go),
    .dividend  (div_dvd),
    .divisor   (div_dvs),
    .quotient  (div_quo),
    .remainder (div_rem),
    .busy      (div_busy),
    .done      (div_done)
  );

  pllc_range #(.FREQ_W(FREQ_W), .HI_LIMIT(HI_LIMIT)) u_range (
    .target (tgt_q),
    .hi     (hi_flag),
    .code   (hi_code)
  );

  pllc_seq #(
    .FREQ_W  (FREQ_W),
    .M_W     (M_W),
    .FRAC_W  (FRAC_W),
    .SD_W    (SD_W),
    .PRE_DIV (PRE_DIV),
    .DIV_W   (DIV_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .clkin_hz (clkin_hz),
    .target   (target),
    .div_busy (div_busy),
    .div_done (div_done),
    .div_quo  (div_quo),
    .div_rem  (div_rem),
    .div_go   (div_go),
    .div_dvd  (div_dvd),
    .div_dvs  (div_dvs),
    .tgt_q    (tgt_q),
    .hi_flag  (hi_flag),
    .hi_code  (hi_code),
    .busy_o   (busy),
    .done_o   (done),
    .err_o    (err),
    .mult_o   (mult),
    .frac_o   (frac),
    .sd_o     (sd_val),
    .hi_o     (hi_range),
    .rsel_o   (range_sel)
  );

  assign pre_div  = PDIV_W'(PRE_DIV);
  assign post_div = POST_W'(1);

endmodule

// File: tb/pllc_top_tb.sv
`timescale 1ns/1ps
module pllc_top_tb_top;

  localparam int NV    = 12;
  localparam int LIMIT = 5000;

  localparam logic [63:0] VECS [NV] = '{
    {32'd19200000,  32'd74250},
    {32'd38400000,  32'd148500},
    {32'd26000000,  32'd100000},
    {32'd26000000,  32'd100001},
    {32'd159999,    32'd5000},
    {32'd160000,    32'd4095},
    {32'd160000,    32'd4096},
    {32'd20000000,  32'd0},
    {32'd400000000, 32'd10000000},
    {32'd12000000,  32'd27027},
    {32'hFFFFFFFF,  32'hFFFFFFFF},
    {32'd100000000, 32'd25200}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] clkin_hz = '0;
  logic [31:0] target = '0;
  logic        busy, done, err, hi_range;
  logic [11:0] mult;
  logic [17:0] frac;
  logic [7:0]  pre_div, sd_val;
  logic [6:0]  post_div;
  logic [2:0]  range_sel;

  int n_chk = 0;
  int n_bad = 0;

  logic             e_err, e_hi;
  longint unsigned  e_m, e_f, e_sd;
  logic [2:0]       e_rs;

  always #10 clk = ~clk;

  pllc_top dut_i (
    .clk(clk), .rst(rst), .start(start), .clkin_hz(clkin_hz), .target(target),
    .busy(busy), .done(done), .err(err), .mult(mult), .frac(frac),
    .pre_div(pre_div), .post_div(post_div), .hi_range(hi_range),
    .sd_val(sd_val), .range_sel(range_sel)
  );

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input longint unsigned ck, input longint unsigned tg);
    longint unsigned c, r, m, x, y, s, f;
    c = ck / 10000;
    r = c / 16;
    e_err = 1'b0;
    m = 0; f = 0; s = 0;
    if (r == 0) e_err = 1'b1;
    else begin
      m = tg / r;
      if (m >= 4096) e_err = 1'b1;
      else begin
        f = ((tg % r) << 18) / r;
        x = (m * c) / 10;
        y = x / 4000;
        s = (y + 5) / 10;
        if (s >= 256) e_err = 1'b1;
      end
    end
    if (e_err) begin m = 0; f = 0; s = 0; end
    e_m = m; e_f = f; e_sd = s;
    e_hi = (tg > 100000);
    e_rs = e_hi ? 3'b100 : 3'b010;
  endtask

  task automatic run_op(input logic [31:0] ck, input logic [31:0] tg, input int mid_at,
                        input logic [31:0] ck2, input logic [31:0] tg2, output int lat);
    @(negedge clk);
    clkin_hz = ck; target = tg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < LIMIT) begin
      if (lat == mid_at) begin
        clkin_hz = ck2; target = tg2; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (lat >= LIMIT) check(1'b0, "R8 done timeout", lat, 0);
  endtask

  task automatic check_results(input string tag);
    check(err == e_err, {tag, " R7 err"}, err, e_err);
    check(mult == e_m, {tag, " R3 mult"}, mult, e_m);
    check(frac == e_f, {tag, " R4 frac"}, frac, e_f);
    check(sd_val == e_sd, {tag, " R6 sd"}, sd_val, e_sd);
    check(hi_range == e_hi, {tag, " R5 hi_range"}, hi_range, e_hi);
    check(range_sel == e_rs, {tag, " R5 range_sel"}, range_sel, e_rs);
    check(!busy, {tag, " R8 busy low at done"}, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ref_lat;
    int lat;
    ref_lat = -1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err, "R1 flags in reset", {busy, done, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(mult == 0 && frac == 0 && sd_val == 0 && !hi_range, "R1 results after reset",
          mult, 0);
    // R2 fixed dividers
    check(pre_div == 8'd16, "R2 pre_div", pre_div, 16);
    check(post_div == 7'd1, "R2 post_div", post_div, 1);

    for (int i = 0; i < NV; i++) begin
      model(VECS[i][63:32], VECS[i][31:0]);
      run_op(VECS[i][63:32], VECS[i][31:0], -1, '0, '0, lat);
      check(done, "R8 done seen", done, 1);
      check_results($sformatf("vec%0d", i));
      if (!e_err) begin
        // R10 fixed latency
        if (ref_lat < 0) ref_lat = lat;
        else check(lat == ref_lat, "R10 latency", lat, ref_lat);
      end
      @(negedge clk);
      check(!done, "R8 done single cycle", done, 0);
    end

    // R9 start while busy is ignored
    model(VECS[1][63:32], VECS[1][31:0]);
    run_op(VECS[1][63:32], VECS[1][31:0], 30, VECS[0][63:32], VECS[0][31:0], lat);
    check_results("R9 mid start");
    check(lat == ref_lat, "R9 latency unchanged", lat, ref_lat);

    // R11 results hold after done
    repeat (12) @(negedge clk);
    check(!done && !busy, "R11 idle after done", {done, busy}, 0);
    check(mult == e_m && frac == e_f && sd_val == e_sd, "R11 mult held", mult, e_m);

    // R1 reset during a calculation
    @(negedge clk);
    clkin_hz = VECS[0][63:32]; target = VECS[0][31:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !err && mult == 0, "R1 mid-op reset", mult, 0);
    rst = 1'b0;
    model(VECS[11][63:32], VECS[11][31:0]);
    run_op(VECS[11][63:32], VECS[11][31:0], -1, '0, '0, lat);
    check_results("R3 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule